// File: doc/BRIEF.md
# Binary-Field Inversion Unit, GF(2^89)

This block computes the multiplicative inverse of a nonzero element of GF(2^89) in polynomial basis. The reduction polynomial is fixed at f(x) = x^89 + x^38 + 1. It runs a modified almost-inverse loop whose final value is the true inverse, so no correction by a power of x follows. A caller pulses `start` with the operand on `operand`. The unit later raises `done` for one cycle with the inverse on `result`. A zero operand is reported through `err` and never enters the loop.

Each loop step does one of two things. If the working polynomial u is even, it divides u by x and divides the companion residue b by x modulo f. Otherwise it swaps the pairs when deg(u) < deg(v) and then adds v into u and c into b. The loop ends when u equals 1. Per clock cycle, `UNROLL` steps are chained together from XOR gates and fixed wiring. Once a stage sees u == 1, it and every later stage in the cycle pass the state through unchanged. A setting of 1 gives a one-step-per-cycle reference mode. The default of 4 needs about a quarter as many loop cycles.

Top module: `ginv_top`

## Requirements
- R1: For every nonzero operand a, the value on `result` while `done` is high satisfies a·result = 1 modulo x^89 + x^38 + 1.
- R2: A zero operand makes `done` and `err` high in the cycle right after the accepting clock edge, and `result` reads 0.
- R3: `done` is high for exactly one cycle per accepted start. `result` and `err` then hold their values until the next accepted start.
- R4: A `start` pulse that arrives while a computation is running has no effect: the running result, its timing and its single `done` pulse are unchanged.
- R5: A nonzero operand that needs N one-step cycles in reference mode (UNROLL = 1) raises `done` after max(1, ceil(N/4)) loop cycles when UNROLL = 4, counted from the accepting edge. So the unrolled unit takes at most about half as many cycles.
- R6: Operand 1 returns 1 after a single loop cycle.
- R7: After synchronous reset, `done`, `err` and `result` are all 0.
- R8: `err` stays low for every nonzero operand.
- R9: The reference mode (UNROLL = 1) produces correct inverses under the same interface.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an inversion when idle |
| operand | input | 89 | Field element to invert, sampled with `start` |
| result | output | 89 | Inverse, valid with `done` and held afterwards |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operand was zero; held with the result |

## Verification
A wrong swap decision, a bad division by x, or a wrong reduction term corrupts the residue b. That shows up at `done` as a product a·result that is not 1, in the same cycle the result appears. A broken freeze after u reaches 1 changes the result, the loop-cycle count, or both, so the bench compares the unrolled unit's cycle count against a reference-mode instance for every operand. A start that slips past the busy guard shows up as a second `done` pulse or as a changed held result within a few cycles after completion.

// File: rtl/ginv_pkg.sv
package ginv_pkg;

    localparam int FLD_M   = 89;
    localparam int MID_EXP = 38;

    typedef logic [FLD_M-1:0] elem_t;
    typedef logic [FLD_M:0]   wide_t;

    localparam wide_t FPOLY = (wide_t'(1) << FLD_M) | (wide_t'(1) << MID_EXP) | wide_t'(1);
    localparam wide_t W_ONE = wide_t'(1);

    typedef struct packed {
        wide_t u;
        wide_t v;
        elem_t b;
        elem_t c;
    } mai_state_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // deg(p) < deg(q), from two magnitude compares instead of leading-one search
    function automatic logic deg_below(wide_t p, wide_t q);
        return (q > p) && ((p ^ q) > p);
    endfunction

    // b / x modulo f
    function automatic elem_t div_by_x(elem_t b);
        wide_t t;
        t = {1'b0, b};
        if (b[0])
            t = t ^ FPOLY;
        return t[FLD_M:1];
    endfunction

    function automatic mai_state_t seed_state(elem_t a);
        mai_state_t s;
        s.u = {1'b0, a};
        s.v = FPOLY;
        s.b = elem_t'(1);
        s.c = '0;
        return s;
    endfunction

endpackage

// File: rtl/ginv_step.sv
module ginv_step
    import ginv_pkg::*;
(
    input  mai_state_t s_in,
    output mai_state_t s_out
);

    always_comb begin
        s_out = s_in;
        if (s_in.u == W_ONE || s_in.u == '0) begin
            s_out = s_in;
        end else if (!s_in.u[0]) begin
            s_out.u = s_in.u >> 1;
            s_out.b = div_by_x(s_in.b);
        end else if (deg_below(s_in.u, s_in.v)) begin
            s_out.u = s_in.u ^ s_in.v;
            s_out.v = s_in.u;
            s_out.b = s_in.b ^ s_in.c;
            s_out.c = s_in.b;
        end else begin
            s_out.u = s_in.u ^ s_in.v;
            s_out.b = s_in.b ^ s_in.c;
        end
    end

    // R1: a live step always changes the state and never drives u to zero
    always_comb begin
        if (s_in.u != W_ONE && s_in.u != '0 && s_in.v[0]) begin
            a_r1_step_moves: assert (s_out != s_in);
            a_r1_u_nonzero:  assert (s_out.u != '0);
        end
    end

endmodule

// File: rtl/ginv_chain.sv
module ginv_chain
    import ginv_pkg::*;
#(
    parameter int UNROLL = 4
) (
    input  mai_state_t cur,
    output mai_state_t nxt
);

    localparam int NSTAGE = (UNROLL < 1) ? 1 : UNROLL;

    mai_state_t link [NSTAGE+1];

    assign link[0] = cur;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        ginv_step u_step (
            .s_in  (link[g]),
            .s_out (link[g+1])
        );
    end

    assign nxt = link[NSTAGE];

endmodule

// File: rtl/ginv_top.sv
module ginv_top
    import ginv_pkg::*;
#(
    parameter int UNROLL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [FLD_M-1:0] operand,
    output logic [FLD_M-1:0] result,
    output logic             done,
    output logic             err
);

    phase_t     phase_q;
    mai_state_t st_q;
    mai_state_t st_nxt;
    elem_t      res_q;
    logic       done_q;
    logic       err_q;
    logic       accept;
    logic       finish;

    ginv_chain #(.UNROLL(UNROLL)) u_chain (
        .cur (st_q),
        .nxt (st_nxt)
    );

    assign accept = (phase_q == PH_IDLE) && start;
    assign finish = (phase_q == PH_RUN) && (st_nxt.u == W_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            st_q    <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (operand == '0) begin
                    res_q  <= '0;
                    err_q  <= 1'b1;
                    done_q <= 1'b1;
                end else begin
                    err_q   <= 1'b0;
                    st_q    <= seed_state(operand);
                    phase_q <= PH_RUN;
                end
            end else if (phase_q == PH_RUN) begin
                st_q <= st_nxt;
                if (finish) begin
                    res_q   <= st_nxt.b;
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
            end
        end
    end

    assign result = res_q;
    assign done   = done_q;
    assign err    = err_q;

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_result_held: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !start) |=> ($stable(result) && $stable(err)));

    a_r2_zero_flags: assert property (@(posedge clk) disable iff (rst)
        (accept && operand == '0) |=> (done && err && result == '0));

    a_r4_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && !finish) |=> (phase_q == PH_RUN && !done));

    a_r8_err_only_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && operand != '0) |=> !err);

endmodule

// File: tb/tb_ginv_top.sv
module tb_ginv_top;
    import ginv_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    elem_t       operand = '0;
    elem_t       res4, res1;
    logic        done4, done1, err4, err1;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    ginv_top #(.UNROLL(4)) dut (
        .clk(clk), .rst(rst), .start(start), .operand(operand),
        .result(res4), .done(done4), .err(err4)
    );

    ginv_top #(.UNROLL(1)) dut_ref (
        .clk(clk), .rst(rst), .start(start), .operand(operand),
        .result(res1), .done(done1), .err(err1)
    );

    function automatic elem_t mulmod(elem_t a, elem_t b);
        elem_t r = '0;
        for (int i = FLD_M - 1; i >= 0; i--) begin
            logic top;
            top = r[FLD_M-1];
            r = r << 1;
            if (top) r = r ^ elem_t'((elem_t'(1) << MID_EXP) | elem_t'(1));
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input elem_t act, input elem_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Runs one inversion on both instances; optional stray start at cycle poke_at
    task automatic run_inv(input elem_t a, input int poke_at,
                           output int d4, output int d1,
                           output elem_t r4, output elem_t r1,
                           output logic e4, output logic e1);
        int cyc;
        d4 = -1; d1 = -1; r4 = '0; r1 = '0; e4 = 1'b0; e1 = 1'b0;
        @(negedge clk);
        start = 1'b1;
        operand = a;
        @(negedge clk);
        start = 1'b0;
        operand = ~a;
        cyc = 0;
        while (1) begin
            if (done4 && d4 < 0) begin d4 = cyc; r4 = res4; e4 = err4; end
            if (done1 && d1 < 0) begin d1 = cyc; r1 = res1; e1 = err1; end
            if (d4 >= 0 && d1 >= 0) break;
            if (cyc > 2000) begin
                check(1'b0, "watchdog", "no done", '0, '0);
                break;
            end
            start = (cyc == poke_at);
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        // R3: single pulse and held outputs afterwards
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!done4, "R3", "done pulse not single", elem_t'(done4), '0);
            check(res4 == r4, "R3", "result not held", res4, r4);
            check(err4 == e4, "R3", "err not held", elem_t'(err4), elem_t'(e4));
        end
    endtask

    task automatic full_check(input elem_t a, input int poke_at, input string tag);
        int d4, d1;
        elem_t r4, r1;
        logic e4, e1;
        run_inv(a, poke_at, d4, d1, r4, r1, e4, e1);
        check(mulmod(a, r4) == elem_t'(1), "R1", {tag, " product"}, mulmod(a, r4), elem_t'(1));
        check(mulmod(a, r1) == elem_t'(1), "R9", {tag, " ref product"}, mulmod(a, r1), elem_t'(1));
        check(!e4 && !e1, "R8", {tag, " err"}, elem_t'(e4), '0);
        check(d1 >= 1 && d4 == (d1 + 3) / 4, "R5", {tag, " cycles"},
              elem_t'(d4), elem_t'((d1 + 3) / 4));
        check(2 * d4 <= d1 + 1, "R5", {tag, " halving"}, elem_t'(2 * d4), elem_t'(d1 + 1));
    endtask

    initial begin
        int d4, d1;
        elem_t r4, r1;
        logic e4, e1;
        elem_t a;
        void'($urandom(32'h1F0A_5C37));

        repeat (3) @(negedge clk);
        // R7: reset state
        check(!done4, "R7", "done after reset", elem_t'(done4), '0);
        check(!err4, "R7", "err after reset", elem_t'(err4), '0);
        check(res4 == '0, "R7", "result after reset", res4, '0);
        rst = 1'b0;

        // R6: operand 1
        run_inv(elem_t'(1), -1, d4, d1, r4, r1, e4, e1);
        check(r4 == elem_t'(1), "R6", "inverse of one", r4, elem_t'(1));
        check(d4 == 1, "R6", "one-cycle latency", elem_t'(d4), elem_t'(1));

        // R2: zero operand
        run_inv('0, -1, d4, d1, r4, r1, e4, e1);
        check(d4 == 0 && e4, "R2", "zero flags", elem_t'(d4), '0);
        check(r4 == '0, "R2", "zero result", r4, '0);

        // Directed edges
        full_check(elem_t'(1) << (FLD_M - 1), -1, "x^88");
        full_check('1, -1, "all ones");
        full_check(elem_t'(2), -1, "x");
        full_check(elem_t'((elem_t'(1) << MID_EXP) | elem_t'(1)), -1, "x^38+1");

        // After an error, a nonzero run must clear err (R8)
        run_inv('0, -1, d4, d1, r4, r1, e4, e1);
        full_check(elem_t'(7), -1, "after zero");

        // Random operands
        for (int n = 0; n < 20; n++) begin
            a = {$urandom, $urandom, $urandom};
            if (a == '0) a = elem_t'(3);
            full_check(a, -1, "random");
        end

        // R4: stray start while busy
        for (int n = 0; n < 3; n++) begin
            a = {$urandom, $urandom, $urandom} | (elem_t'(1) << (FLD_M - 1));
            full_check(a, 2 + n, "R4 stray start");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule